// File: doc/BRIEF.md
# Converter Control Byte Decoder

This block is the digital control side of a multichannel data converter. A 2-wire slave byte receiver passes every write byte it accepts, one strobe per byte. The most significant bit of the byte selects its destination. When that bit is 1, the byte loads the setup register, which holds a reference-select field, a clock-source bit and a polarity bit. When that bit is 0, the byte loads the configuration register, which holds an input-mode flag and a channel-select field. A setup byte can also ask for the configuration register to go back to its default.

The block combines the polarity bit and the input-mode flag into the coding that applies to results. It then turns a raw signed 9-bit differential sample into an 8-bit output code. Unipolar coding is straight binary and clamps negative inputs to zero. Bipolar coding is two's complement and saturates at the ends of the signed 8-bit range. Single-ended mode always uses unipolar coding.

Top module: `adc_ctrl_decoder`

## Requirements
- R1: After reset, the outputs are: `ref_sel`=000, `clk_ext`=0, `bipolar`=0, `single_ended`=1, `chan_sel`=0 and `code_out`=0.
- R2: A strobed byte with bit 7 = 1 loads three setup fields on the next clock edge: `ref_sel` from byte bits 6:4, `clk_ext` from bit 3 and `bipolar` from bit 2.
- R3: A strobed byte with bit 7 = 0 loads two configuration fields on the next clock edge: `single_ended` from byte bit 0 and `chan_sel` from bits 4:1. The setup fields do not change.
- R4: A setup byte with bit 1 = 0 returns the configuration register to its default (`single_ended`=1, `chan_sel`=0). With bit 1 = 1, a setup byte leaves the configuration register unchanged.
- R5: Setup byte bit 0 and configuration byte bits 6:5 have no effect on any output.
- R6: While `wr_stb` is low, every register output holds its value, whatever is on `wr_byte`.
- R7: Bipolar coding applies only when `bipolar`=1 and `single_ended`=0. Every other combination uses unipolar coding.
- R8: With unipolar coding, `code_out` equals the sample clamped to the range 0..255. It appears one clock edge after the sample is presented.
- R9: With bipolar coding, `code_out` is the 8-bit two's complement form of the sample clamped to the range -128..127. It appears one clock edge after the sample is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle strobe marking a received byte |
| wr_byte | input | 8 | Received byte |
| smp_raw | input | 9 | Signed raw differential sample |
| ref_sel | output | 3 | Reference-select field |
| clk_ext | output | 1 | Clock source (1 external, 0 internal) |
| bipolar | output | 1 | Polarity bit (1 bipolar) |
| single_ended | output | 1 | Input mode (1 single-ended, 0 pseudo-differential) |
| chan_sel | output | 4 | Channel-select field |
| code_out | output | 8 | Formatted output code |

## Verification
Register fields and the formatted code are each due exactly one rising edge after their stimulus. Every register field follows the edge that captures a strobed byte. The code follows the edge that captures a sample under the coding already held in the registers. The bench drives all inputs on falling edges and reads outputs on the next falling edge, half a period after the capturing edge. It sweeps all 256 byte values and all 512 sample values under each of the four mode combinations, and compares the results against an arithmetic model.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
    localparam int BYTE_W = 8;
    localparam int REF_W  = 3;
    localparam int CHAN_W = 4;

    typedef struct packed {
        logic [REF_W-1:0] ref_sel;
        logic             clk_ext;
        logic             bipolar;
    } setup_t;

    typedef struct packed {
        logic              single_ended;
        logic [CHAN_W-1:0] chan;
    } cfg_t;

    localparam setup_t SETUP_RST = '{ref_sel: '0, clk_ext: 1'b0, bipolar: 1'b0};
    localparam cfg_t   CFG_RST   = '{single_ended: 1'b1, chan: '0};
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    output setup_t            setup_o,
    output cfg_t              cfg_o
);
    localparam int SEL_BIT  = BYTE_W - 1;
    localparam int RST_BIT  = 1;
    localparam int SE_BIT   = 0;
    localparam int REF_LSB  = 4;
    localparam int CLK_BIT  = 3;
    localparam int POL_BIT  = 2;
    localparam int CHAN_LSB = 1;

    typedef struct packed {
        setup_t setup;
        cfg_t   cfg;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_stb) begin
            if (wr_byte[SEL_BIT]) begin
                regs_d.setup.ref_sel = wr_byte[REF_LSB +: REF_W];
                regs_d.setup.clk_ext = wr_byte[CLK_BIT];
                regs_d.setup.bipolar = wr_byte[POL_BIT];
                if (!wr_byte[RST_BIT]) begin
                    regs_d.cfg = CFG_RST;
                end
            end else begin
                regs_d.cfg.single_ended = wr_byte[SE_BIT];
                regs_d.cfg.chan         = wr_byte[CHAN_LSB +: CHAN_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{setup: SETUP_RST, cfg: CFG_RST};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign setup_o = regs_q.setup;
    assign cfg_o   = regs_q.cfg;

    p_setup_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_byte[SEL_BIT]) |=>
            (setup_o.ref_sel == $past(wr_byte[REF_LSB +: REF_W])) &&
            (setup_o.bipolar == $past(wr_byte[POL_BIT])));

    p_setup_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_byte[SEL_BIT]) |=> $stable(setup_o));

    p_cfg_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_byte[SEL_BIT] && !wr_byte[RST_BIT]) |=>
            (cfg_o.single_ended && cfg_o.chan == '0));

    p_cfg_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_byte[SEL_BIT] && wr_byte[RST_BIT]) |=> $stable(cfg_o));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(cfg_o) && $stable(setup_o)));
endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt #(
    parameter int SMP_W  = 9,
    parameter int CODE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bip_eff,
    input  logic signed [SMP_W-1:0] smp_i,
    output logic        [CODE_W-1:0] code_o
);
    localparam int UMAX = (1 << CODE_W) - 1;
    localparam int BMAX = (1 << (CODE_W - 1)) - 1;
    localparam int BMIN = -(1 << (CODE_W - 1));

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } fmt_t;

    fmt_t fmt_d, fmt_q;
    int   sv;
    int   lim;

    always_comb begin
        sv  = int'(smp_i);
        lim = sv;
        if (bip_eff) begin
            if (sv > BMAX)      lim = BMAX;
            else if (sv < BMIN) lim = BMIN;
        end else begin
            if (sv > UMAX)      lim = UMAX;
            else if (sv < 0)    lim = 0;
        end
        fmt_d.code = lim[CODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q <= '0;
        end else begin
            fmt_q <= fmt_d;
        end
    end

    assign code_o = fmt_q.code;

    p_uni_neg_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bip_eff && smp_i < 0) |=> (code_o == '0));

    p_bip_top_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bip_eff && int'(smp_i) > BMAX) |=> (code_o == CODE_W'(BMAX)));

    p_bip_low_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bip_eff && int'(smp_i) < BMIN) |=> (code_o == CODE_W'(BMIN)));
endmodule

// File: rtl/adc_ctrl_decoder.sv
module adc_ctrl_decoder
    import adc_ctrl_pkg::*;
#(
    parameter int SMP_W  = 9,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  logic [BYTE_W-1:0]        wr_byte,
    input  logic signed [SMP_W-1:0]  smp_raw,
    output logic [REF_W-1:0]         ref_sel,
    output logic                     clk_ext,
    output logic                     bipolar,
    output logic                     single_ended,
    output logic [CHAN_W-1:0]        chan_sel,
    output logic [CODE_W-1:0]        code_out
);
    setup_t setup_w;
    cfg_t   cfg_w;
    logic   bip_eff;

    adc_ctrl_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .setup_o (setup_w),
        .cfg_o   (cfg_w)
    );

    // Single-ended inputs always use unipolar coding
    assign bip_eff = setup_w.bipolar & ~cfg_w.single_ended;

    adc_code_fmt #(.SMP_W(SMP_W), .CODE_W(CODE_W)) i_fmt (
        .clk     (clk),
        .rst_n   (rst_n),
        .bip_eff (bip_eff),
        .smp_i   (smp_raw),
        .code_o  (code_out)
    );

    assign ref_sel      = setup_w.ref_sel;
    assign clk_ext      = setup_w.clk_ext;
    assign bipolar      = setup_w.bipolar;
    assign single_ended = cfg_w.single_ended;
    assign chan_sel     = cfg_w.chan;

    p_se_unipolar_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (single_ended && smp_raw < 0) |=> (code_out == '0));
endmodule

// File: tb/test_adc_ctrl_decoder.sv
module test_adc_ctrl_decoder;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_stb = 1'b0;
    logic [7:0]        wr_byte = '0;
    logic signed [8:0] smp_raw = '0;
    logic [2:0]        ref_sel;
    logic              clk_ext, bipolar, single_ended;
    logic [3:0]        chan_sel;
    logic [7:0]        code_out;

    int checks = 0;
    int errors = 0;

    logic [2:0] m_ref = 3'd0;
    logic       m_clk = 1'b0, m_bip = 1'b0, m_se = 1'b1;
    logic [3:0] m_ch  = 4'd0;

    always #10 clk = ~clk;

    adc_ctrl_decoder i_adc_ctrl_decoder (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .smp_raw(smp_raw), .ref_sel(ref_sel), .clk_ext(clk_ext),
        .bipolar(bipolar), .single_ended(single_ended),
        .chan_sel(chan_sel), .code_out(code_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        check({tag, " ref_sel"}, int'(ref_sel), int'(m_ref));
        check({tag, " clk_ext"}, int'(clk_ext), int'(m_clk));
        check({tag, " bipolar"}, int'(bipolar), int'(m_bip));
        check({tag, " single_ended"}, int'(single_ended), int'(m_se));
        check({tag, " chan_sel"}, int'(chan_sel), int'(m_ch));
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_byte = b;
        @(negedge clk);
        wr_stb  = 1'b0;
        if (b[7]) begin
            m_ref = b[6:4]; m_clk = b[3]; m_bip = b[2];
            if (!b[1]) begin m_se = 1'b1; m_ch = 4'd0; end
        end else begin
            m_se = b[0]; m_ch = b[4:1];
        end
    endtask

    function automatic int exp_code(input int s, input logic bip_e);
        int l;
        l = s;
        if (bip_e) begin
            if (l > 127) l = 127;
            if (l < -128) l = -128;
            return l & 255;
        end
        if (l > 255) l = 255;
        if (l < 0) l = 0;
        return l;
    endfunction

    task automatic sweep_samples(input string tag);
        logic be;
        be = m_bip & ~m_se;
        for (int s = -256; s < 256; s++) begin
            @(negedge clk);
            smp_raw = 9'(s);
            @(negedge clk);
            check(tag, int'(code_out), exp_code(s, be));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check_regs("R1");
        check("R1 code_out", int'(code_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R5: every byte value; ignored bits are covered by the model
        for (int b = 0; b < 256; b++) begin
            write_byte(8'(b));
            if (b >= 128) begin
                if ((b & 2) == 0) check_regs("R2 R4 R5 setup byte reset");
                else              check_regs("R2 R4 R5 setup byte keep");
            end else begin
                check_regs("R3 R5 config byte");
            end
        end

        // R6: idle cycles with a changing byte
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            wr_byte = 8'(k * 37 + 3);
            @(negedge clk);
            check_regs("R6 idle hold");
        end

        // R8: single-ended, unipolar
        write_byte(8'h80);
        write_byte(8'h01);
        sweep_samples("R8 unipolar single-ended");
        // R9: pseudo-differential, bipolar (setup byte keeps config with bit 1 set)
        write_byte(8'h00);
        write_byte(8'h86);
        check_regs("R9 mode");
        sweep_samples("R9 bipolar");
        // R7: bipolar bit with single-ended input stays unipolar
        write_byte(8'h07);
        check_regs("R7 mode");
        sweep_samples("R7 single-ended overrides bipolar");
        // R8: pseudo-differential, unipolar
        write_byte(8'h82);
        write_byte(8'h00);
        sweep_samples("R8 unipolar pseudo-differential");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule